// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table from main memory. A caller hands it one translation at a time, together with the kind of access it intends (data read, data write or instruction fetch). The walker first bounds the top index against a programmed table length. It then reads the top-level entry, follows it to the second-level table and reads the leaf entry. It checks validity and access rights, and answers with either a physical address or a fault code.

The virtual address is cut, from the top bit down, into a 12-bit top index, a 10-bit second index and a 10-bit page offset. Pages are 1 KB. Table entries are 32-bit words fetched over a simple request/response port. A request is a one-cycle strobe with an address. The response may arrive any number of cycles later, flagged by its valid strobe. The table origin and the table length are held in two configuration registers. These registers may only change while no walk is running.

Top module: `xlat_walker`

## Requirements
- R1: After reset the walker is idle: `reqReady` is 1 and `memReqValid`, `doneValid` and `faultValid` are 0.
- R2: The first memory read of an accepted walk goes to `{origin[31:2],2'b00} + 4*vaddr[31:20]`. The origin is written with `cfgWe=1, cfgSel=0`, and its two low bits are ignored.
- R3: The table length is written with `cfgWe=1, cfgSel=1` from `cfgData[12:0]`. If `vaddr[31:20]` is greater than or equal to the length, the walk ends with `faultCode=0` and makes no memory read.
- R4: When the top entry has bit 0 set, the second read goes to `{entry[31:10],10'b0} + 4*vaddr[19:10]`.
- R5: A top entry with bit 0 clear ends the walk with `faultCode=1` after exactly one read. A leaf entry with bit 0 clear ends it with `faultCode=2`.
- R6: Leaf bits 2:1 give the rights: 0 read-only, 1 read-write, 2 execute-only, 3 reserved. With `reqKind` 0 (read) or 3 (also read), access is allowed on 0 and 1. With 1 (write), access is allowed on 1 only. With 2 (fetch), access is allowed on 0, 1 and 2. Any other pairing ends the walk with `faultCode=3`.
- R7: A successful walk raises `doneValid` for one cycle, with `donePaddr = {leaf[31:10], vaddr[9:0]}`. At most one of `doneValid` and `faultValid` is high, and only for one cycle.
- R8: `reqReady` is 0 from the cycle after acceptance through the result cycle, and 1 in the cycle after it. This holds for any response delay. Memory reads are issued only while `reqReady` is 0.
- R9: Configuration writes made while `reqReady` is 0 are ignored. Writes made while it is 1 take effect for later walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 selects table origin, 1 selects table length |
| cfgData | input | 32 | Configuration write value |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle, request accepted when both high |
| reqVaddr | input | 32 | Virtual address to translate |
| reqKind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| memReqValid | output | 1 | One-cycle memory word read strobe |
| memReqAddr | output | 32 | Byte address of the table entry read |
| memRespValid | input | 1 | Memory read data present |
| memRespData | input | 32 | Table entry word |
| doneValid | output | 1 | One-cycle successful translation pulse |
| donePaddr | output | 32 | Translated physical address |
| faultValid | output | 1 | One-cycle fault pulse |
| faultCode | output | 2 | 0 length, 1 bad top entry, 2 bad leaf, 3 rights |

## Verification
A walk sequencer stuck in or skipping a state shows up in the next walk. Depending on the fault, the walk makes the wrong number of memory reads, reads the wrong entry address, leaves `reqReady` low, or produces a result with no pulse. Each of these is visible within one or two cycles of the response that should have moved the walk on. A corrupted origin, length or captured address affects every later translation, and the first such walk exposes it at its first read or in its fault code. The bench sweeps all access kinds against every rights code, covers indices below, at and above the length, and uses varied response delays. It compares each read address and each result against values worked out arithmetically from the table contents.

// File: rtl/xw_pkg.sv
package xw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OUTER_REQ, ST_OUTER_WAIT, ST_INNER_REQ, ST_INNER_WAIT, ST_DONE
  } walk_st_e;

  typedef enum logic [1:0] {
    FLT_LEN = 2'd0, FLT_OUTER = 2'd1, FLT_LEAF = 2'd2, FLT_PROT = 2'd3
  } fault_e;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [1:0] PR_RO = 2'd0;
  localparam logic [1:0] PR_RW = 2'd1;
  localparam logic [1:0] PR_XO = 2'd2;

  typedef struct packed {
    logic   capReq;
    logic   capOuter;
    logic   capLeaf;
    logic   setFault;
    fault_e faultCode;
    logic   selInner;
  } ctl_t;
endpackage

// File: rtl/xw_perm.sv
module xw_perm
  import xw_pkg::*;
(
  input  logic [1:0] kind,
  input  logic [1:0] prot,
  output logic       permOk
);
  always_comb begin
    case (prot)
      PR_RO:   permOk = (kind != ACC_WRITE);
      PR_RW:   permOk = 1'b1;
      PR_XO:   permOk = (kind == ACC_FETCH);
      default: permOk = 1'b0;
    endcase
  end
endmodule

// File: rtl/xw_ctrl.sv
module xw_ctrl
  import xw_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic lenBad,
  input  logic memRespValid,
  input  logic entryValid,
  input  logic permOk,
  output ctl_t ctl,
  output logic reqReady,
  output logic memReqValid,
  output logic doneValid,
  output logic faultValid
);
  walk_st_e stQ, stD;
  logic isFaultQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ      <= ST_IDLE;
      isFaultQ <= 1'b0;
    end else begin
      stQ <= stD;
      if (ctl.setFault)    isFaultQ <= 1'b1;
      else if (ctl.capReq) isFaultQ <= 1'b0;
    end
  end

  always_comb begin
    stD = stQ;
    ctl = '0;
    ctl.faultCode = FLT_LEN;
    case (stQ)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.capReq = 1'b1;
          if (lenBad) begin
            ctl.setFault  = 1'b1;
            ctl.faultCode = FLT_LEN;
            stD = ST_DONE;
          end else begin
            stD = ST_OUTER_REQ;
          end
        end
      end
      ST_OUTER_REQ: stD = ST_OUTER_WAIT;
      ST_OUTER_WAIT: begin
        if (memRespValid) begin
          if (!entryValid) begin
            ctl.setFault  = 1'b1;
            ctl.faultCode = FLT_OUTER;
            stD = ST_DONE;
          end else begin
            ctl.capOuter = 1'b1;
            stD = ST_INNER_REQ;
          end
        end
      end
      ST_INNER_REQ: begin
        ctl.selInner = 1'b1;
        stD = ST_INNER_WAIT;
      end
      ST_INNER_WAIT: begin
        ctl.selInner = 1'b1;
        if (memRespValid) begin
          stD = ST_DONE;
          if (!entryValid) begin
            ctl.setFault  = 1'b1;
            ctl.faultCode = FLT_LEAF;
          end else if (!permOk) begin
            ctl.setFault  = 1'b1;
            ctl.faultCode = FLT_PROT;
          end else begin
            ctl.capLeaf = 1'b1;
          end
        end
      end
      ST_DONE: stD = ST_IDLE;
      default: stD = ST_IDLE;
    endcase
  end

  assign reqReady    = (stQ == ST_IDLE);
  assign memReqValid = (stQ == ST_OUTER_REQ) || (stQ == ST_INNER_REQ);
  assign doneValid   = (stQ == ST_DONE) && !isFaultQ;
  assign faultValid  = (stQ == ST_DONE) && isFaultQ;
endmodule

// File: rtl/xw_dpath.sv
module xw_dpath
  import xw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 10,
  parameter int IN_W  = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_t             ctl,
  input  logic             cfgOpen,
  input  logic             cfgWe,
  input  logic             cfgSel,
  input  logic [VA_W-1:0]  cfgData,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [1:0]       reqKind,
  input  logic [VA_W-1:0]  memRespData,
  output logic             lenBad,
  output logic             entryValid,
  output logic             permOk,
  output logic [VA_W-1:0]  memReqAddr,
  output logic [VA_W-1:0]  donePaddr,
  output logic [1:0]       faultCode
);
  localparam int OUT_W  = VA_W - OFF_W - IN_W;
  localparam int LEN_W  = OUT_W + 1;
  localparam int FRM_W  = VA_W - OFF_W;
  localparam int ENT_SH = 2;

  logic [VA_W-ENT_SH-1:0] baseQ;
  logic [LEN_W-1:0]       lenQ;
  logic [VA_W-1:0]        vaddrQ;
  logic [1:0]             kindQ;
  logic [FRM_W-1:0]       innerBaseQ;
  logic [VA_W-1:0]        paddrQ;
  fault_e                 faultQ;

  logic [OUT_W-1:0] reqIdx, outerIdx;
  logic [IN_W-1:0]  innerIdx;
  logic [VA_W-1:0]  outerAddr, innerAddr;
  logic             unusedBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ      <= '0;
      lenQ       <= '0;
      vaddrQ     <= '0;
      kindQ      <= '0;
      innerBaseQ <= '0;
      paddrQ     <= '0;
      faultQ     <= FLT_LEN;
    end else begin
      if (cfgWe && cfgOpen) begin
        if (cfgSel) lenQ  <= cfgData[LEN_W-1:0];
        else        baseQ <= cfgData[VA_W-1:ENT_SH];
      end
      if (ctl.capReq) begin
        vaddrQ <= reqVaddr;
        kindQ  <= reqKind;
      end
      if (ctl.capOuter) innerBaseQ <= memRespData[VA_W-1:OFF_W];
      if (ctl.capLeaf)  paddrQ <= {memRespData[VA_W-1:OFF_W], vaddrQ[OFF_W-1:0]};
      if (ctl.setFault) faultQ <= ctl.faultCode;
    end
  end

  assign reqIdx   = reqVaddr[VA_W-1 -: OUT_W];
  assign outerIdx = vaddrQ[VA_W-1 -: OUT_W];
  assign innerIdx = vaddrQ[OFF_W +: IN_W];
  assign lenBad   = ({1'b0, reqIdx} >= lenQ);

  assign outerAddr = {baseQ, {ENT_SH{1'b0}}} + VA_W'({outerIdx, {ENT_SH{1'b0}}});
  assign innerAddr = {innerBaseQ, {OFF_W{1'b0}}} + VA_W'({innerIdx, {ENT_SH{1'b0}}});
  assign memReqAddr = ctl.selInner ? innerAddr : outerAddr;

  assign entryValid = memRespData[0];

  xw_perm perm_i (
    .kind   (kindQ),
    .prot   (memRespData[2:1]),
    .permOk (permOk)
  );

  assign donePaddr  = paddrQ;
  assign faultCode  = faultQ;
  assign unusedBits = ^{cfgData[ENT_SH-1:0], memRespData[OFF_W-1:3]};
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 10,
  parameter int IN_W  = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWe,
  input  logic            cfgSel,
  input  logic [VA_W-1:0] cfgData,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [VA_W-1:0] reqVaddr,
  input  logic [1:0]      reqKind,
  output logic            memReqValid,
  output logic [VA_W-1:0] memReqAddr,
  input  logic            memRespValid,
  input  logic [VA_W-1:0] memRespData,
  output logic            doneValid,
  output logic [VA_W-1:0] donePaddr,
  output logic            faultValid,
  output logic [1:0]      faultCode
);
  ctl_t ctl;
  logic lenBad, entryValid, permOk;

  xw_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .lenBad       (lenBad),
    .memRespValid (memRespValid),
    .entryValid   (entryValid),
    .permOk       (permOk),
    .ctl          (ctl),
    .reqReady     (reqReady),
    .memReqValid  (memReqValid),
    .doneValid    (doneValid),
    .faultValid   (faultValid)
  );

  xw_dpath #(.VA_W(VA_W), .OFF_W(OFF_W), .IN_W(IN_W)) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .cfgOpen     (reqReady),
    .cfgWe       (cfgWe),
    .cfgSel      (cfgSel),
    .cfgData     (cfgData),
    .reqVaddr    (reqVaddr),
    .reqKind     (reqKind),
    .memRespData (memRespData),
    .lenBad      (lenBad),
    .entryValid  (entryValid),
    .permOk      (permOk),
    .memReqAddr  (memReqAddr),
    .donePaddr   (donePaddr),
    .faultCode   (faultCode)
  );
endmodule

// File: rtl/xw_chk.sv
module xw_chk #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 10
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic [VA_W-1:0] reqVaddr,
  input logic            memReqValid,
  input logic            doneValid,
  input logic [VA_W-1:0] donePaddr,
  input logic            faultValid,
  input logic [1:0]      faultCode
);
  logic [1:0]       readCnt;
  logic [OFF_W-1:0] offQ;
  logic             unusedChk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readCnt <= '0;
      offQ    <= '0;
    end else if (reqValid && reqReady) begin
      readCnt <= '0;
      offQ    <= reqVaddr[OFF_W-1:0];
    end else if (memReqValid && readCnt != 2'd3) begin
      readCnt <= readCnt + 2'd1;
    end
  end

  assign unusedChk = ^reqVaddr[VA_W-1:OFF_W];

  AST_LEN_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && faultCode == 2'd0) |-> readCnt == 2'd0); // R3
  AST_TWO_READS: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> readCnt == 2'd2); // R4
  AST_OUTER_ONE_READ: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && faultCode == 2'd1) |-> readCnt == 2'd1); // R5
  AST_LEAF_FAULT_READS: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && faultCode[1]) |-> readCnt == 2'd2); // R6
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> donePaddr[OFF_W-1:0] == offQ); // R7
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    !(doneValid && faultValid)); // R7
  AST_PULSE_THEN_READY: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid || faultValid) |=> (!doneValid && !faultValid && reqReady)); // R8
  AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady); // R8
endmodule

bind xlat_walker xw_chk #(.VA_W(VA_W), .OFF_W(OFF_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .reqVaddr    (reqVaddr),
  .memReqValid (memReqValid),
  .doneValid   (doneValid),
  .donePaddr   (donePaddr),
  .faultValid  (faultValid),
  .faultCode   (faultCode)
);

// File: tb/xlat_walker_tb_top.sv
module xlat_walker_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0, cfgSel = 1'b0;
  logic [31:0] cfgData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqKind = '0;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRespValid = 1'b0;
  logic [31:0] memRespData = '0;
  logic        doneValid;
  logic [31:0] donePaddr;
  logic        faultValid;
  logic [1:0]  faultCode;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  xlat_walker dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr), .reqKind(reqKind),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRespValid(memRespValid), .memRespData(memRespData),
    .doneValid(doneValid), .donePaddr(donePaddr),
    .faultValid(faultValid), .faultCode(faultCode)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Table image: top table at 0x1000, top entry i points to 0x10000*(i+1),
  // entry 2 invalid; leaf j has rights j%4, invalid when j%5==3.
  function automatic logic [31:0] memWord(logic [31:0] addr);
    int i, j, frame;
    if (addr < 32'h10000) begin
      i = int'((addr - 32'h1000) >> 2);
      return ((i + 1) << 16) | ((i == 2) ? 0 : 1);
    end
    i = int'(addr >> 16) - 1;
    j = int'((addr & 32'hFFFF) >> 2);
    frame = (i * 37 + j * 11 + 5) & 32'h3FFFFF;
    return (frame << 10) | ((j % 4) << 1) | ((j % 5 != 3) ? 1 : 0);
  endfunction

  task automatic cfgWrite(bit sel, logic [31:0] val);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgData = val;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic doWalk(int i, int j, int kind, int lenv, int stall, bit poke);
    logic [31:0] va, lastAddr, expPa;
    logic [9:0]  off;
    int reads, w, prot, expCode, expReads;
    bit pending, seen, gotFault, expFault, readyLowOk;
    logic [31:0] gotPa;
    int gotCode;
    off = 10'((i * 97 + j * 13 + kind) & 32'h3FF);
    va = {i[11:0], j[9:0], off};
    // expected outcome from the requirements
    prot = j % 4;
    expFault = 1; expCode = 0; expReads = 0; expPa = '0;
    if (i >= lenv) begin
      expCode = 0; expReads = 0;                          // R3
    end else if (i == 2) begin
      expCode = 1; expReads = 1;                          // R5
    end else if (j % 5 == 3) begin
      expCode = 2; expReads = 2;                          // R5
    end else if (prot == 3 || (kind == 1 && prot != 1) ||
                 ((kind == 0 || kind == 3) && prot == 2)) begin
      expCode = 3; expReads = 2;                          // R6
    end else begin
      expFault = 0; expReads = 2;
      expPa = {22'((i * 37 + j * 11 + 5) & 32'h3FFFFF), off}; // R7
    end

    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqKind = kind[1:0];
    @(negedge clk);
    reqValid = 1'b0;
    reads = 0; pending = 0; seen = 0; w = 0; lastAddr = '0;
    readyLowOk = 1; gotFault = 0; gotCode = 0; gotPa = '0;
    for (int it = 0; it < 200; it++) begin
      memRespValid = 1'b0;
      if (poke) begin
        if (it == 0) begin cfgWe = 1'b1; cfgSel = 1'b1; cfgData = 32'd0; end
        if (it == 1) cfgWe = 1'b0;
      end
      if (reqReady) readyLowOk = 0;
      if (doneValid || faultValid) begin
        seen = 1; gotFault = faultValid; gotCode = int'(faultCode); gotPa = donePaddr;
        if (doneValid && faultValid) chk(0, "R7", "both pulses", 1, 0);
        break;
      end
      if (memReqValid) begin
        reads++;
        lastAddr = memReqAddr;
        if (reads == 1)
          chk(memReqAddr == 32'h1000 + 4 * i, "R2", "top entry address", memReqAddr, 32'h1000 + 4 * i);
        else if (reads == 2)
          chk(memReqAddr == 32'h10000 * (i + 1) + 4 * j, "R4", "leaf address",
              memReqAddr, 32'h10000 * (i + 1) + 4 * j);
        pending = 1; w = stall;
      end else if (pending) begin
        if (w == 0) begin
          memRespValid = 1'b1; memRespData = memWord(lastAddr); pending = 0;
        end else w--;
      end
      @(negedge clk);
    end
    memRespValid = 1'b0;
    cfgWe = 1'b0;
    chk(seen, "R7", "walk produced an outcome", seen, 1);
    chk(readyLowOk, "R8", "ready low while busy", readyLowOk, 1);
    chk(reads == expReads, expFault ? "R5" : "R4", "read count", reads, expReads);
    if (expFault)
      chk(gotFault && gotCode == expCode, expCode == 3 ? "R6" : (expCode == 0 ? "R3" : "R5"),
          "fault code", gotFault ? gotCode : -1, expCode);
    else
      chk(!gotFault && gotPa == expPa, "R7", "physical address", gotFault ? -1 : gotPa, expPa);
    @(negedge clk);
    chk(reqReady && !doneValid && !faultValid, "R8", "ready after pulse", reqReady, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(reqReady, "R1", "reqReady", reqReady, 1);
    chk(!memReqValid, "R1", "memReqValid", memReqValid, 0);
    chk(!doneValid && !faultValid, "R1", "result pulses", {doneValid, faultValid}, 0);

    cfgWrite(1'b0, 32'h0000_1003);   // R2 low bits ignored
    cfgWrite(1'b1, 32'd4);

    for (int i = 0; i < 6; i++)
      for (int jj = 0; jj < 13; jj++)
        for (int k = 0; k < 4; k++)
          doWalk(i, (jj == 12) ? 1023 : jj, k, 4, (i + jj + k) % 3, 1'b0);

    // R9 write during a walk is ignored, the length stays 4
    doWalk(1, 0, 0, 4, 2, 1'b1);
    doWalk(3, 1, 0, 4, 0, 1'b0);

    // R9 idle write takes effect; R3 boundary at the top of the index range
    cfgWrite(1'b1, 32'd4096);
    doWalk(4095, 5, 1, 4096, 7, 1'b0);
    doWalk(4095, 1, 2, 4096, 4, 1'b0);
    cfgWrite(1'b1, 32'd4095);
    doWalk(4095, 5, 0, 4095, 0, 1'b0);
    cfgWrite(1'b1, 32'd0);
    doWalk(0, 0, 0, 0, 0, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule